// File: doc/BRIEF.md
# Interrupt Request Controller with Set/Clear Writes

This block gathers six single-cycle event pulses from neighbouring units into a bank of sticky request flags. An enable flag per source decides whether a pending request counts toward the interrupt. The neighbours are a countdown timer, the transmit and receive paths, the command engine and a FIFO with high and low watermarks. A combined status bit is the OR of every enabled pending request. A registered, active-high interrupt pin follows that status one clock later.

The processor reaches both flag registers through a small port with a one-cycle write strobe, a register select and combinational read data. Writes do not carry data in the usual sense. The top bit of the written byte picks the action: 1 sets flags and 0 clears them. Each lower bit that is 1 marks a flag to act on, and each bit that is 0 leaves its flag alone. Software can therefore acknowledge or force one source without a read-modify-write. If a hardware event and a software clear strike the same request flag in the same cycle, the event wins and is not lost.

The block has no sequencing of its own. Each flag is a small set/clear register, and the only stateful output path is the one-cycle pipeline stage on the interrupt pin.

Top module: `irq_ctrl`

## Requirements
- R1: After reset, both registers read 0x00 and `irq_status` and `irq_o` are 0.
- R2: A write with `wr_data[7]`=1 sets to 1 every flag of the selected register whose data bit (5:0) is 1.
- R3: A write with `wr_data[7]`=0 clears to 0 every flag of the selected register whose data bit (5:0) is 1.
- R4: In any write, a flag whose data bit is 0 keeps its value.
- R5: Writing 0x3F to the request register clears all six request flags. Writing 0x81 sets only the low-alert flag (bit 0) and leaves the others unchanged.
- R6: An event pulse sets its request flag at the next clock edge. The bit positions are timer 5, transmit end 4, receive end 3, command idle 2, FIFO high alert 1 and FIFO low alert 0.
- R7: When an event pulse and a software clear of the same request flag occur in the same cycle, the flag ends up at 1.
- R8: Read bits 7 and 6 of both registers are always 0. Writes whose only marked bit is bit 6 change nothing.
- R9: `irq_status` is 1 exactly when some request flag and its enable flag are both 1.
- R10: `irq_o` equals the value that `irq_status` had in the previous cycle.
- R11: The enable register is written with the same set/clear rule (`wr_sel`=1, read `rd_sel`=1) and is never changed by request writes or events. The request register is selected with 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | One-cycle write strobe |
| wr_sel | input | 1 | Write target: 0 request, 1 enable |
| wr_data | input | 8 | Bit 7 action (1 set, 0 clear), bits 5:0 flag mask |
| rd_sel | input | 1 | Read source: 0 request, 1 enable |
| rd_data | output | 8 | Selected register, bits 7:6 zero |
| ev_timer | input | 1 | Timer expired pulse |
| ev_tx | input | 1 | Transmit stream ended pulse |
| ev_rx | input | 1 | Receive stream ended pulse |
| ev_idle | input | 1 | Command finished pulse |
| ev_hi | input | 1 | FIFO high-alert pulse |
| ev_lo | input | 1 | FIFO low-alert pulse |
| irq_status | output | 1 | OR of enabled pending requests |
| irq_o | output | 1 | Registered interrupt pin, active high |

## Verification
The properties assume that every input is a clean binary value on each rising edge once reset is released. They also assume that the clear-wins-or-loses question only arises on the request register, since events never touch enable flags. The stimulus keeps to this by changing inputs only on the falling edge and by dropping the strobe and the event pulses shortly after each rising edge. Each pulse is therefore seen by exactly one edge, and the combinational read port is sampled only while the inputs are quiet.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
    localparam int REG_W    = 8;
    localparam int FLAG_N   = 6;
    localparam int ACT_BIT  = REG_W - 1;
    localparam int PAD_W    = REG_W - FLAG_N;

    localparam int POS_TIMER = 5;
    localparam int POS_TX    = 4;
    localparam int POS_RX    = 3;
    localparam int POS_IDLE  = 2;
    localparam int POS_HI    = 1;
    localparam int POS_LO    = 0;

    typedef enum logic {
        SEL_REQ = 1'b0,
        SEL_EN  = 1'b1
    } reg_sel_e;
endpackage

// File: rtl/irq_bitreg.sv
module irq_bitreg #(
    parameter int N      = 6,
    parameter bit HW_SET = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_hit,
    input  logic         wr_set,
    input  logic [N-1:0] wr_mask,
    input  logic [N-1:0] hw_evt,
    output logic [N-1:0] q
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        logic sw_next;
        logic nxt;

        always_comb begin
            sw_next = q[i];
            if (wr_hit && wr_mask[i]) begin
                sw_next = wr_set;
            end
        end

        if (HW_SET) begin : g_hw
            // hardware event dominates a same-cycle software clear
            assign nxt = sw_next | hw_evt[i];
        end else begin : g_sw
            assign nxt = sw_next;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                q[i] <= nxt;
            end
        end
    end
endmodule

// File: rtl/irq_merge.sv
module irq_merge #(
    parameter int N = 6
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic [N-1:0] en,
    output logic         status,
    output logic         pin
);
    assign status = |(req & en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pin <= 1'b0;
        end else begin
            pin <= status;
        end
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_ctrl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [REG_W-1:0] wr_data,
    input  logic             rd_sel,
    output logic [REG_W-1:0] rd_data,
    input  logic             ev_timer,
    input  logic             ev_tx,
    input  logic             ev_rx,
    input  logic             ev_idle,
    input  logic             ev_hi,
    input  logic             ev_lo,
    output logic             irq_status,
    output logic             irq_o
);
    logic [FLAG_N-1:0] req_q;
    logic [FLAG_N-1:0] en_q;
    logic [FLAG_N-1:0] ev_vec;
    logic [FLAG_N-1:0] mask;
    logic              act_set;
    logic              hit_req;
    logic              hit_en;

    always_comb begin
        ev_vec            = '0;
        ev_vec[POS_TIMER] = ev_timer;
        ev_vec[POS_TX]    = ev_tx;
        ev_vec[POS_RX]    = ev_rx;
        ev_vec[POS_IDLE]  = ev_idle;
        ev_vec[POS_HI]    = ev_hi;
        ev_vec[POS_LO]    = ev_lo;
    end

    assign mask    = wr_data[FLAG_N-1:0];
    assign act_set = wr_data[ACT_BIT];
    assign hit_req = wr_en && (reg_sel_e'(wr_sel) == SEL_REQ);
    assign hit_en  = wr_en && (reg_sel_e'(wr_sel) == SEL_EN);

    irq_bitreg #(.N(FLAG_N), .HW_SET(1'b1)) u_req (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit_req),
        .wr_set (act_set),
        .wr_mask(mask),
        .hw_evt (ev_vec),
        .q      (req_q)
    );

    irq_bitreg #(.N(FLAG_N), .HW_SET(1'b0)) u_en (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (hit_en),
        .wr_set (act_set),
        .wr_mask(mask),
        .hw_evt ('0),
        .q      (en_q)
    );

    irq_merge #(.N(FLAG_N)) u_merge (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req_q),
        .en    (en_q),
        .status(irq_status),
        .pin   (irq_o)
    );

    always_comb begin
        unique case (reg_sel_e'(rd_sel))
            SEL_REQ: rd_data = {{PAD_W{1'b0}}, req_q};
            SEL_EN:  rd_data = {{PAD_W{1'b0}}, en_q};
            default: rd_data = '0;
        endcase
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk
    import irq_ctrl_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [REG_W-1:0]  wr_data,
    input logic [FLAG_N-1:0] ev,
    input logic [FLAG_N-1:0] req,
    input logic [FLAG_N-1:0] en,
    input logic [REG_W-1:0]  rd_data,
    input logic              irq_status,
    input logic              irq_o
);
    logic              w_req;
    logic [FLAG_N-1:0] m;
    assign w_req = wr_en && !wr_sel;
    assign m     = wr_data[FLAG_N-1:0];

    p_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (w_req && wr_data[ACT_BIT]) |=> ((req & $past(m)) == $past(m)));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (w_req && !wr_data[ACT_BIT]) |=> ((req & $past(m & ~ev)) == '0));

    p_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
        w_req |=> ((req & ~$past(m | ev)) == ($past(req) & ~$past(m | ev))));

    p_event_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (ev != '0) |=> ((req & $past(ev)) == $past(ev)));

    p_pad_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[REG_W-1:FLAG_N] == '0);

    p_status_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_status == ((req & en) != '0));

    p_pin_delay_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == $past(irq_status));

    p_en_isolated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_sel) |=> $stable(en));
endmodule

bind irq_ctrl irq_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_sel    (wr_sel),
    .wr_data   (wr_data),
    .ev        ({ev_timer, ev_tx, ev_rx, ev_idle, ev_hi, ev_lo}),
    .req       (req_q),
    .en        (en_q),
    .rd_data   (rd_data),
    .irq_status(irq_status),
    .irq_o     (irq_o)
);

// File: tb/sim_irq_ctrl.sv
module sim_irq_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 16;

    typedef struct packed {
        logic       wr;
        logic       sel;
        logic [7:0] data;
        logic [5:0] ev;
        logic [5:0] exp_req;
        logic [5:0] exp_en;
        logic       exp_st;
    } vec_t;

    // ev order: timer, tx, rx, idle, hi, lo (bits 5..0)
    localparam vec_t TBL [NVEC] = '{
        '{1'b1, 1'b1, 8'hBF, 6'h00, 6'h00, 6'h3F, 1'b0}, // R11 enable all
        '{1'b1, 1'b0, 8'h81, 6'h00, 6'h01, 6'h3F, 1'b1}, // R5 0x81
        '{1'b1, 1'b0, 8'hA4, 6'h00, 6'h25, 6'h3F, 1'b1}, // R2 set 5,2
        '{1'b1, 1'b0, 8'h04, 6'h00, 6'h21, 6'h3F, 1'b1}, // R3 R4 clear 2
        '{1'b1, 1'b0, 8'h3F, 6'h00, 6'h00, 6'h3F, 1'b0}, // R5 0x3F
        '{1'b0, 1'b0, 8'h00, 6'h20, 6'h20, 6'h3F, 1'b1}, // R6 timer
        '{1'b0, 1'b0, 8'h00, 6'h18, 6'h38, 6'h3F, 1'b1}, // R6 tx+rx
        '{1'b1, 1'b0, 8'h08, 6'h08, 6'h38, 6'h3F, 1'b1}, // R7 event beats clear
        '{1'b1, 1'b1, 8'h3F, 6'h00, 6'h38, 6'h00, 1'b0}, // R3 R11 enable clear
        '{1'b1, 1'b1, 8'h82, 6'h00, 6'h38, 6'h02, 1'b0}, // R9 no overlap
        '{1'b0, 1'b0, 8'h00, 6'h02, 6'h3A, 6'h02, 1'b1}, // R6 R9 hi alert
        '{1'b1, 1'b0, 8'hC0, 6'h00, 6'h3A, 6'h02, 1'b1}, // R8 set bit6 only
        '{1'b1, 1'b0, 8'h40, 6'h00, 6'h3A, 6'h02, 1'b1}, // R8 clear bit6 only
        '{1'b1, 1'b1, 8'h02, 6'h00, 6'h3A, 6'h00, 1'b0}, // R4 R11 enable off
        '{1'b0, 1'b0, 8'h00, 6'h05, 6'h3F, 6'h00, 1'b0}, // R6 idle+lo
        '{1'b1, 1'b0, 8'h3F, 6'h00, 6'h00, 6'h00, 1'b0}  // R5 clear all
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       rd_sel = 1'b0;
    logic [7:0] rd_data;
    logic [5:0] ev = 6'h00;
    logic       irq_status;
    logic       irq_o;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
        .ev_timer(ev[5]), .ev_tx(ev[4]), .ev_rx(ev[3]),
        .ev_idle(ev[2]), .ev_hi(ev[1]), .ev_lo(ev[0]),
        .irq_status(irq_status), .irq_o(irq_o)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_regs(input string tag, input logic [5:0] er, input logic [5:0] ee);
        rd_sel = 1'b0;
        #1;
        check({tag, " req"}, rd_data, {2'b00, er});
        rd_sel = 1'b1;
        #1;
        check({tag, " en"}, rd_data, {2'b00, ee});
        rd_sel = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic prev_st;
        repeat (3) @(posedge clk);
        #2;
        check_regs("R1 reset", 6'h00, 6'h00);
        check("R1 status", {7'd0, irq_status}, 8'd0);
        check("R1 pin", {7'd0, irq_o}, 8'd0);
        @(negedge clk);
        rst_n = 1'b1;
        prev_st = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            wr_en   = TBL[k].wr;
            wr_sel  = TBL[k].sel;
            wr_data = TBL[k].data;
            ev      = TBL[k].ev;
            @(posedge clk);
            #2;
            wr_en = 1'b0;
            ev    = 6'h00;
            check_regs($sformatf("R2/R3/R6 vec%0d", k), TBL[k].exp_req, TBL[k].exp_en);
            check($sformatf("R9 vec%0d", k), {7'd0, irq_status}, {7'd0, TBL[k].exp_st});
            check($sformatf("R10 vec%0d", k), {7'd0, irq_o}, {7'd0, prev_st});
            prev_st = TBL[k].exp_st;
        end

        // R10: pin catches up one cycle after the last status change
        @(posedge clk);
        #2;
        check("R10 settle", {7'd0, irq_o}, {7'd0, prev_st});

        // R1: reset in mid-run with flags and enables set
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hBF;
        ev = 6'h3F;
        @(negedge clk);
        wr_en = 1'b0; ev = 6'h00;
        @(negedge clk);
        check("R9 all pending", {7'd0, irq_status}, 8'd1);
        check("R10 all pending", {7'd0, irq_o}, 8'd1);
        rst_n = 1'b0;
        @(posedge clk);
        #2;
        check_regs("R1 midrun", 6'h00, 6'h00);
        check("R1 pin midrun", {7'd0, irq_o}, 8'd0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule